// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address. It uses a two-level paging scheme with 4 KiB pages, 10-bit table indices and 4-byte table entries. A request carries the address, the access kind (fetch, load or store) and the current privilege. Along with it come the translation root page number, a translation-enable bit and four status controls: user-page access from supervisor mode, execute-implies-readable, data-access privilege override, and the previous privilege used by that override.

The walker reads table entries through a simple request/acknowledge memory port. When a leaf entry needs its accessed or dirty bit set, it writes the updated entry back through the same port. The walk ends with a one-cycle `done` pulse. With it come the physical address, read/write/execute grants and a fault flag, all held in registers until the next request completes.

Entry layout: bit 0 valid, bit 1 readable, bit 2 writable, bit 3 executable, bit 4 user, bit 6 accessed, bit 7 dirty, bits 31:10 physical page number. Privilege codes: 0 user, 1 supervisor, 3 machine. Access kind codes: 0 fetch, 1 load, 2 store.

Top module: `pt_walker2`

## Requirements
- R1: While `rst` is high and in the cycle after it, `req_ready` is 1 and `done`, `fault` and `mem_req` are 0.
- R2: If the effective privilege is machine (3) or `xlat_on` is 0, the walk makes no memory access. It completes with `phys_addr` equal to the zero-extended virtual address, all three grants set, and no fault.
- R3: With privilege 3, `data_prev_en` set and a non-fetch access, the effective privilege is `prev_priv`. A fetch always uses the request privilege.
- R4: The first entry is read at (`root_ppn` << 12) + vaddr[31:22]*4. The second entry is read at (pointer PPN << 12) + vaddr[21:12]*4.
- R5: An entry whose valid bit (bit 0) is 0 ends the walk with a fault.
- R6: An entry with bits 3:1 all zero is a pointer. A pointer at the second level ends the walk with a fault.
- R7: Leaf entries with writable set and readable clear are reserved and fault, whether executable is set or not.
- R8: A user page (bit 4 set) faults unless the effective privilege is user, or `sup_user_ok` is set and the access is not a fetch. A non-user page faults unless the effective privilege is supervisor.
- R9: A first-level leaf whose PPN bits 9:0 are not all zero faults.
- R10: A load needs readable, or executable with `exec_readable` set. A store needs writable. A fetch needs executable.
- R11: On success the accessed bit (bit 6) is set, and for stores also the dirty bit (bit 7). If this changes the entry, the new entry is written back to the address it was read from before `done`. Otherwise no write takes place.
- R12: A second-level leaf gives {PPN, vaddr[11:0]}. A first-level leaf gives {PPN[21:10], vaddr[21:0]}.
- R13: On success, `grant_r` = readable | (executable & `exec_readable`), `grant_x` = executable, and `grant_w` = writable & (store | dirty). On a fault all grants and `phys_addr` are 0.
- R14: `done` lasts one cycle. `req_ready` is high only when the walker is idle. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when `req_ready` is high |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| xlat_on | input | 1 | 1 selects two-level translation, 0 bare |
| root_ppn | input | 22 | Page number of the first-level table |
| sup_user_ok | input | 1 | Supervisor may load/store user pages |
| exec_readable | input | 1 | Executable pages are readable |
| data_prev_en | input | 1 | Machine-mode data accesses use `prev_priv` |
| prev_priv | input | 2 | Privilege used when the override applies |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 34 | Entry byte address |
| mem_wdata | output | 32 | Entry write data |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | 32 | Entry read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk failed |
| phys_addr | output | 34 | Translated address |
| grant_r | output | 1 | Read permitted |
| grant_w | output | 1 | Write permitted |
| grant_x | output | 1 | Execute permitted |

## Verification
The bench aims at the points where a walker most often goes wrong.

- **Privilege override.** A design that applied the override to fetches would translate a machine-mode fetch instead of passing it through.
- **Superpages.** A design that skipped the superpage alignment check, or built the address from the wrong bits, would return a shifted address.
- **Pointer at the last level.** A design that treated it as a leaf, or kept walking, would either fault too late or hang.
- **User pages from supervisor mode.** Each side of the rule is probed: fetch versus load, and the opt-in bit set versus clear.
- **Accessed/dirty write-back.** Every memory transaction is logged, so a missing, surplus or misaddressed write shows up as a miscompare.
- **Write grant on clean pages.** Loads to writable pages without the dirty bit are checked, since granting write there would let a later store bypass dirty tracking.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_WB,
    ST_DONE
  } walk_st_t;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  // entry bit positions
  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int B_A = 6;
  localparam int B_D = 7;
  localparam int PTE_PPN_LSB = 10;
endpackage

// File: rtl/ptw_mode_sel.sv
module ptw_mode_sel
  import ptw_pkg::*;
(
  input  logic [1:0] priv,
  input  logic [1:0] kind,
  input  logic [1:0] prev_priv,
  input  logic       data_prev_en,
  input  logic       xlat_on,
  output logic [1:0] eff_priv,
  output logic       bypass
);
  always_comb begin
    eff_priv = priv;
    if (priv == PRIV_M && kind != ACC_FETCH && data_prev_en)
      eff_priv = prev_priv;
    bypass = (eff_priv == PRIV_M) || !xlat_on;
  end
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int IDX_W = 10,
  localparam int PPN_W = PTE_W - PTE_PPN_LSB
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             first_lvl,
  input  logic [1:0]       eff_priv,
  input  logic [1:0]       kind,
  input  logic             sum_en,
  input  logic             mxr_en,
  output logic             descend,
  output logic             fault,
  output logic             gr,
  output logic             gw,
  output logic             gx,
  output logic             wb_need,
  output logic [PTE_W-1:0] pte_upd
);
  logic v, r, w, x, u, d;
  logic is_ptr, is_store, is_fetch, is_load;
  logic rsvd, user_bad, sup_bad, misal, perm_bad, leaf_bad;
  logic [PPN_W-1:0] ppn;

  assign v   = pte[B_V];
  assign r   = pte[B_R];
  assign w   = pte[B_W];
  assign x   = pte[B_X];
  assign u   = pte[B_U];
  assign d   = pte[B_D];
  assign ppn = pte[PTE_W-1:PTE_PPN_LSB];

  assign is_store = (kind == ACC_STORE);
  assign is_fetch = (kind == ACC_FETCH);
  assign is_load  = !is_store && !is_fetch;
  assign is_ptr   = !r && !w && !x;

  assign rsvd     = w && !r;
  assign user_bad = u && (eff_priv != PRIV_U) && (!sum_en || is_fetch);
  assign sup_bad  = !u && (eff_priv != PRIV_S);
  assign misal    = first_lvl && (ppn[IDX_W-1:0] != '0);
  assign perm_bad = (is_load && !(r || (x && mxr_en))) ||
                    (is_store && !w) ||
                    (is_fetch && !x);
  assign leaf_bad = rsvd || user_bad || sup_bad || misal || perm_bad;

  assign descend = v && is_ptr && first_lvl;
  assign fault   = !v || (is_ptr && !first_lvl) || (!is_ptr && leaf_bad);

  assign gr = r || (x && mxr_en);
  assign gx = x;
  assign gw = w && (is_store || d);

  always_comb begin
    pte_upd = pte;
    pte_upd[B_A] = 1'b1;
    if (is_store) pte_upd[B_D] = 1'b1;
  end
  assign wb_need = (pte_upd != pte);
endmodule

// File: rtl/ptw_addr_unit.sv
module ptw_addr_unit
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PTE_W = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  localparam int LEVELS = 2,
  localparam int PPN_W  = PTE_W - PTE_PPN_LSB,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [PPN_W-1:0] leaf_ppn,
  input  logic [VA_W-1:0]  va,
  input  logic             lvl_second,
  output logic [PA_W-1:0]  ent_addr,
  output logic [PA_W-1:0]  leaf_pa
);
  localparam int ENT_SH = OFF_W - IDX_W;

  logic [IDX_W-1:0] vpn [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_vpn
    assign vpn[g] = va[OFF_W + g*IDX_W +: IDX_W];
  end

  logic [IDX_W-1:0] idx;
  assign idx      = lvl_second ? vpn[0] : vpn[LEVELS-1];
  assign ent_addr = {base_ppn, idx, {ENT_SH{1'b0}}};

  always_comb begin
    if (lvl_second) leaf_pa = {leaf_ppn, va[OFF_W-1:0]};
    else            leaf_pa = {leaf_ppn[PPN_W-1:IDX_W], va[OFF_W+IDX_W-1:0]};
  end
endmodule

// File: rtl/pt_walker2.sv
module pt_walker2
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PTE_W = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  localparam int PPN_W = PTE_W - PTE_PPN_LSB,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_priv,
  input  logic             xlat_on,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic             sup_user_ok,
  input  logic             exec_readable,
  input  logic             data_prev_en,
  input  logic [1:0]       prev_priv,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  phys_addr,
  output logic             grant_r,
  output logic             grant_w,
  output logic             grant_x
);
  walk_st_t         st;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       kind_q, eff_q;
  logic             sum_q, mxr_q, lvl_q;
  logic [PPN_W-1:0] base_q;
  logic [PTE_W-1:0] pte_q;

  logic             res_fault, res_r, res_w, res_x;
  logic [PA_W-1:0]  res_pa;

  logic [1:0]       eff_now;
  logic             bypass_now;
  logic             lc_descend, lc_fault, lc_gr, lc_gw, lc_gx, lc_wb;
  logic [PTE_W-1:0] lc_upd;
  logic [PA_W-1:0]  ent_addr, leaf_pa;

  ptw_mode_sel u_mode (
    .priv         (req_priv),
    .kind         (req_kind),
    .prev_priv    (prev_priv),
    .data_prev_en (data_prev_en),
    .xlat_on      (xlat_on),
    .eff_priv     (eff_now),
    .bypass       (bypass_now)
  );

  ptw_leaf_check #(.PTE_W(PTE_W), .IDX_W(IDX_W)) u_leaf (
    .pte       (pte_q),
    .first_lvl (!lvl_q),
    .eff_priv  (eff_q),
    .kind      (kind_q),
    .sum_en    (sum_q),
    .mxr_en    (mxr_q),
    .descend   (lc_descend),
    .fault     (lc_fault),
    .gr        (lc_gr),
    .gw        (lc_gw),
    .gx        (lc_gx),
    .wb_need   (lc_wb),
    .pte_upd   (lc_upd)
  );

  ptw_addr_unit #(.VA_W(VA_W), .PTE_W(PTE_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
    .base_ppn   (base_q),
    .leaf_ppn   (pte_q[PTE_W-1:PTE_PPN_LSB]),
    .va         (va_q),
    .lvl_second (lvl_q),
    .ent_addr   (ent_addr),
    .leaf_pa    (leaf_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      va_q      <= '0;
      kind_q    <= '0;
      eff_q     <= '0;
      sum_q     <= 1'b0;
      mxr_q     <= 1'b0;
      lvl_q     <= 1'b0;
      base_q    <= '0;
      pte_q     <= '0;
      res_fault <= 1'b0;
      res_r     <= 1'b0;
      res_w     <= 1'b0;
      res_x     <= 1'b0;
      res_pa    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            kind_q <= req_kind;
            eff_q  <= eff_now;
            sum_q  <= sup_user_ok;
            mxr_q  <= exec_readable;
            lvl_q  <= 1'b0;
            base_q <= root_ppn;
            if (bypass_now) begin
              res_fault <= 1'b0;
              res_r     <= 1'b1;
              res_w     <= 1'b1;
              res_x     <= 1'b1;
              res_pa    <= {{(PA_W-VA_W){1'b0}}, req_vaddr};
              st        <= ST_DONE;
            end else begin
              st <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            pte_q <= mem_rdata;
            st    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (lc_fault) begin
            res_fault <= 1'b1;
            res_r     <= 1'b0;
            res_w     <= 1'b0;
            res_x     <= 1'b0;
            res_pa    <= '0;
            st        <= ST_DONE;
          end else if (lc_descend) begin
            base_q <= pte_q[PTE_W-1:PTE_PPN_LSB];
            lvl_q  <= 1'b1;
            st     <= ST_READ;
          end else begin
            res_fault <= 1'b0;
            res_r     <= lc_gr;
            res_w     <= lc_gw;
            res_x     <= lc_gx;
            res_pa    <= leaf_pa;
            if (lc_wb) begin
              pte_q <= lc_upd;
              st    <= ST_WB;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        ST_WB: begin
          if (mem_ack) st <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st == ST_READ) || (st == ST_WB);
  assign mem_we    = (st == ST_WB);
  assign mem_addr  = ent_addr;
  assign mem_wdata = pte_q;
  assign done      = (st == ST_DONE);
  assign fault     = res_fault;
  assign phys_addr = res_pa;
  assign grant_r   = res_r;
  assign grant_w   = res_w;
  assign grant_x   = res_x;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
  import ptw_pkg::*;
#(
  parameter int PA_W  = 34,
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             done,
  input logic             fault,
  input logic             grant_r,
  input logic             grant_w,
  input logic             grant_x,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [PA_W-1:0]  mem_addr,
  input logic [PA_W-1:0]  phys_addr,
  input logic [PTE_W-1:0] mem_wdata
);
  localparam logic [PTE_W-1:0] AV_MASK = PTE_W'((1 << B_A) | (1 << B_V));

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (req_ready && !done && !mem_req && !fault));

  p_done_pulse_r14: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_req_hold_r14: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_idle_quiet_r14: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_req && !done));

  p_fault_clean_r13: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (!grant_r && !grant_w && !grant_x && phys_addr == '0));

  p_w_needs_r_r7: assert property (@(posedge clk) disable iff (rst)
    (done && grant_w) |-> grant_r);

  p_wb_marks_a_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ((mem_wdata & AV_MASK) == AV_MASK));
endmodule

bind pt_walker2 ptw_checker #(.PA_W(PA_W), .PTE_W(PTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .done      (done),
  .fault     (fault),
  .grant_r   (grant_r),
  .grant_w   (grant_w),
  .grant_x   (grant_x),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .phys_addr (phys_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/test_pt_walker2.sv
`timescale 1ns/1ps
module test_pt_walker2;
  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                         FU = 8'h10, FA = 8'h40, FD = 8'h80;
  localparam logic [1:0] K_F = 2'd0, K_L = 2'd1, K_S = 2'd2;
  localparam logic [1:0] P_U = 2'd0, P_S = 2'd1, P_M = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0, req_priv = '0, prev_priv = '0;
  logic xlat_on = 1'b0, sup_user_ok = 1'b0, exec_readable = 1'b0, data_prev_en = 1'b0;
  logic [21:0] root_ppn = '0;
  logic mem_req, mem_we, mem_ack;
  logic [33:0] mem_addr, phys_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic done, fault, grant_r, grant_w, grant_x;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [0:2047];
  int rd_cnt, wr_cnt, lat;
  logic [33:0] rd_a0, wr_addr;
  logic [31:0] wr_data;

  always #2 clk = ~clk;

  pt_walker2 i_pt_walker2 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_priv(req_priv),
    .xlat_on(xlat_on), .root_ppn(root_ppn), .sup_user_ok(sup_user_ok),
    .exec_readable(exec_readable), .data_prev_en(data_prev_en), .prev_priv(prev_priv),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .phys_addr(phys_addr), .grant_r(grant_r), .grant_w(grant_w), .grant_x(grant_x)
  );

  function automatic logic [31:0] rdw(input logic [33:0] a);
    return (a < 34'd8192) ? mem[a[12:2]] : 32'h0;
  endfunction

  function automatic logic [31:0] mk(input logic [21:0] ppn, input logic [7:0] f);
    return {ppn, 2'b00, f};
  endfunction

  // memory responder with random latency
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; lat = 0;
    rd_cnt = 0; wr_cnt = 0; rd_a0 = '0; wr_addr = '0; wr_data = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (lat > 0) lat = lat - 1;
        else begin
          if (mem_we) begin
            if (mem_addr < 34'd8192) mem[mem_addr[12:2]] = mem_wdata;
            wr_cnt = wr_cnt + 1; wr_addr = mem_addr; wr_data = mem_wdata;
          end else begin
            if (rd_cnt == 0) rd_a0 = mem_addr;
            rd_cnt = rd_cnt + 1;
            mem_rdata = rdw(mem_addr);
          end
          mem_ack = 1'b1;
          lat = $urandom % 3;
        end
      end
    end
  end

  function automatic void ref_walk(
    input logic [31:0] va, input logic [1:0] kind, priv, input logic xl,
    input logic [21:0] root, input logic sm, mx, mp, input logic [1:0] pp,
    output logic ef, output logic [33:0] epa, output logic er, ew, ex,
    output logic ewb, output logic [33:0] ewa, output logic [31:0] ewd,
    output int enr, output logic [33:0] ea0);
    logic [1:0] eff;
    logic [21:0] base, ppn;
    logic [31:0] pte, upd;
    logic [33:0] a;
    logic v, r, w, x, u, d, st, fe, ld, bad;
    ef = 1'b1; epa = '0; er = 0; ew = 0; ex = 0; ewb = 0; ewa = '0; ewd = '0;
    enr = 0; ea0 = '0;
    eff = (priv == P_M && kind != K_F && mp) ? pp : priv;
    if (eff == P_M || !xl) begin
      ef = 0; epa = {2'b00, va}; er = 1; ew = 1; ex = 1; return;
    end
    base = root;
    for (int lvl = 0; lvl < 2; lvl++) begin
      a = {base, (lvl == 0) ? va[31:22] : va[21:12], 2'b00};
      if (lvl == 0) ea0 = a;
      enr = enr + 1;
      pte = rdw(a);
      v = pte[0]; r = pte[1]; w = pte[2]; x = pte[3]; u = pte[4]; d = pte[7];
      ppn = pte[31:10];
      st = (kind == K_S); fe = (kind == K_F); ld = !st && !fe;
      if (!v) return;
      if (!r && !w && !x) begin
        if (lvl == 1) return;
        base = ppn;
        continue;
      end
      bad = (w && !r)
         || (u && eff != P_U && (!sm || fe))
         || (!u && eff != P_S)
         || (lvl == 0 && ppn[9:0] != 0)
         || (ld && !(r || (x && mx))) || (st && !w) || (fe && !x);
      if (bad) return;
      ef = 0;
      epa = (lvl == 1) ? {ppn, va[11:0]} : {ppn[21:10], va[21:0]};
      er = r || (x && mx); ex = x; ew = w && (st || d);
      upd = pte | {24'h0, FA} | (st ? {24'h0, FD} : 32'h0);
      if (upd != pte) begin ewb = 1; ewa = a; ewd = upd; end
      return;
    end
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] va, input logic [1:0] kind,
                     input logic [1:0] priv, input logic xl, input logic [21:0] root,
                     input logic sm, input logic mx, input logic mp, input logic [1:0] pp);
    logic ef, er, ew, ex, ewb;
    logic [33:0] epa, ewa, ea0;
    logic [31:0] ewd;
    int enr, n;
    ref_walk(va, kind, priv, xl, root, sm, mx, mp, pp,
             ef, epa, er, ew, ex, ewb, ewa, ewd, enr, ea0);
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_priv = priv; xlat_on = xl; root_ppn = root;
    sup_user_ok = sm; exec_readable = mx; data_prev_en = mp; prev_priv = pp;
    rd_cnt = 0; wr_cnt = 0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    if (n >= 1000) begin
      n_chk++; n_bad++;
      $display("FAIL %s timeout: actual no done expected done", tag);
      return;
    end
    chk(tag, "fault", 64'(fault), 64'(ef));
    chk(tag, "phys_addr", 64'(phys_addr), 64'(epa));
    chk(tag, "grants rwx", 64'({grant_r, grant_w, grant_x}), 64'({er, ew, ex}));
    chk(tag, "reads", 64'(rd_cnt), 64'(enr));
    if (enr > 0) chk(tag, "first entry addr", 64'(rd_a0), 64'(ea0));
    chk(tag, "writes", 64'(wr_cnt), 64'(ewb));
    if (ewb) begin
      chk(tag, "wb addr", 64'(wr_addr), 64'(ewa));
      chk(tag, "wb data", 64'(wr_data), 64'(ewd));
    end
    @(negedge clk);
    chk("R14", "done pulse/ready", 64'({done, req_ready}), 64'(2'b01));
  endtask

  function automatic logic [31:0] rand_ent(input bit as_ptr_ok);
    logic [31:0] e;
    int sel;
    sel = $urandom % 5;
    e = $urandom;
    if (sel == 0) e[0] = 1'b0;
    else if (sel == 1 && as_ptr_ok) e = mk(22'd1, FV);
    else if (sel == 1) e = mk(22'd7, FV);
    else begin
      e[0] = 1'b1;
      if (e[3:1] == 3'b000) e[1] = 1'b1;
      if ($urandom % 2) e[19:10] = '0;
    end
    return e;
  endfunction

  function automatic logic [1:0] rand_priv();
    int p;
    p = $urandom % 3;
    return (p == 2) ? P_M : 2'(p);
  endfunction

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL R14 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] va1, va2;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "ready/done/fault/mem_req in reset",
        64'({req_ready, done, fault, mem_req}), 64'(4'b1000));
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "after reset", 64'({req_ready, done, fault, mem_req}), 64'(4'b1000));

    va1 = {10'd5, 10'd9, 12'h123};
    va2 = {10'd700, 10'd33, 12'hABC};
    mem[5] = mk(22'd1, FV);
    mem[1024 + 9] = mk(22'h2ABCD, FV | FR | FW | FA | FD);

    run("R2", va1, K_L, P_S, 1'b0, 22'd0, 0, 0, 0, P_U);
    run("R2", va1, K_S, P_M, 1'b1, 22'd0, 0, 0, 0, P_U);
    run("R3", va1, K_L, P_M, 1'b1, 22'd0, 0, 0, 1, P_S);
    run("R3", va1, K_F, P_M, 1'b1, 22'd0, 0, 0, 1, P_S);
    run("R4", va1, K_L, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);
    run("R12", va1, K_S, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);

    mem[1024 + 9] = mk(22'h01234, FV | FR | FW);
    run("R11", va1, K_S, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);
    run("R11", va1, K_S, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);
    mem[1024 + 9] = mk(22'h01234, FV | FR);
    run("R11", va1, K_L, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);

    mem[5] = mk(22'h00C00, FV | FR | FA);
    run("R12", va1, K_L, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);
    mem[5] = mk(22'h00C01, FV | FR | FA);
    run("R9", va1, K_L, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);
    mem[5] = mk(22'd1, FR | FA);
    run("R5", va1, K_L, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);

    mem[5] = mk(22'd1, FV);
    mem[1024 + 9] = mk(22'd1, FV);
    run("R6", va1, K_L, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);
    mem[1024 + 9] = mk(22'h00055, FV | FW | FA | FD);
    run("R7", va1, K_S, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);
    mem[1024 + 9] = mk(22'h00055, FV | FW | FX | FA | FD);
    run("R7", va1, K_F, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);

    mem[1024 + 9] = mk(22'h00077, FV | FU | FR | FX | FA);
    run("R8", va1, K_L, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);
    run("R8", va1, K_L, P_S, 1'b1, 22'd0, 1, 0, 0, P_U);
    run("R8", va1, K_F, P_S, 1'b1, 22'd0, 1, 0, 0, P_U);
    run("R8", va1, K_F, P_U, 1'b1, 22'd0, 0, 0, 0, P_U);
    mem[1024 + 9] = mk(22'h00077, FV | FR | FX | FA);
    run("R8", va1, K_L, P_U, 1'b1, 22'd0, 0, 0, 0, P_U);

    mem[1024 + 9] = mk(22'h00099, FV | FX | FA);
    run("R10", va1, K_L, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);
    run("R10", va1, K_L, P_S, 1'b1, 22'd0, 0, 1, 0, P_U);
    run("R10", va1, K_F, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);
    run("R10", va1, K_S, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);

    mem[1024 + 9] = mk(22'h000AA, FV | FR | FW | FA);
    run("R13", va1, K_L, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);
    mem[1024 + 9] = mk(22'h000AA, FV | FR | FW | FA | FD);
    run("R13", va1, K_L, P_S, 1'b1, 22'd0, 0, 0, 0, P_U);

    mem[1024 + 700] = mk(22'h3FC00, FV | FR | FX | FA);
    run("R4", va2, K_F, P_S, 1'b1, 22'd1, 0, 0, 0, P_U);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] va;
      logic [21:0] root;
      va = $urandom;
      root = ($urandom % 4 == 0) ? 22'd1 : 22'd0;
      mem[{root[0], va[31:22]}] = rand_ent(1'b1);
      mem[1024 + int'(va[21:12])] = rand_ent(1'b0);
      run("R13", va, 2'($urandom % 3), rand_priv(), ($urandom % 8) != 0, root,
          1'($urandom), 1'($urandom), 1'($urandom), rand_priv());
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule